// File: doc/BRIEF.md
# Posted Write Drain Sequencer

This block acts as the bus master on the target side of a bridge. It empties one buffered posted write at a time onto a PCI-style bus. A posted write is offered as a job: a start address and a length in DWORDs. The sequencer asks for the bus, runs an address phase, and then offers one DWORD per data cycle from the head of the write buffer. It pops the buffer for each DWORD that the target accepts.

A burst can stop in several ways, and each one leads to its own follow-up:

- **Normal completion.** Every DWORD has been delivered. The request is released and the job is finished.
- **Target disconnect or target retry.** The burst stops. The sequencer keeps requesting the bus and later opens a fresh transaction for the leftover DWORDs, at the address where the data stopped.
- **Target abort.** The leftover DWORDs are thrown away and a sticky error flag is raised. Software clears that flag by writing one to it.
- **Latency timer expiry.** A latency timer is loaded at each address phase. If it runs out while the grant is withdrawn, the sequencer gives up the bus early and resumes later, just as it does after a disconnect.

Top module: `pws_drain_seq`

## Requirements
- R1: After reset, `bus_req`, `tx_frame`, `tx_addr_phase`, `tx_data_phase` and `sts_abort` are all low.
- R2: An accepted job with a non-zero length raises `bus_req`. An address phase (`tx_addr_phase`, with `tx_frame`) happens only in the cycle after `bus_gnt` was sampled high while requesting. The first address phase of a job presents `job_addr`.
- R3: In a data cycle, a DWORD is taken when `tgt_ready` is high and neither `tgt_retry` nor `tgt_abort` is high. In that same cycle `buf_pop` pulses and `tx_wdata` equals `buf_rdata`. No DWORD is taken at any other time.
- R4: When the last DWORD of the job is taken, `xfer_done` pulses in that cycle. In the next cycle `tx_frame` and `bus_req` are both low.
- R5: `tgt_retry` ends the burst without moving data. `tgt_disconnect` ends it after the DWORD taken in that cycle, if there is one. In both cases `tx_frame` is low in the next cycle.
- R6: Every later address phase of the same job presents `job_addr` plus four times the number of DWORDs taken so far.
- R7: `tgt_abort` in a data cycle takes no DWORD, even when `tgt_ready` is high. `xfer_drop` pulses in that cycle and the rest of the job is discarded. In the next cycle `tx_frame` and `bus_req` are low.
- R8: `sts_abort` is set by a target abort and stays set until `sts_abort_clr` is high in a cycle without a new abort. If an abort and a clear arrive in the same cycle, the abort wins.
- R9: `lat_init` is loaded at each address phase. The N-th data cycle of a burst (counting from 0) has timed out when N >= `lat_init`. A timed-out data cycle with `bus_gnt` low ends the burst, and `tx_frame` is low in the next cycle. While `bus_gnt` stays high, the timer never ends a burst.
- R10: Between a burst that ends early without an abort and the next address phase, `bus_req` stays high.
- R11: A job of length zero is accepted with `job_ack` and `xfer_done` in the same cycle. It produces no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| job_valid | input | 1 | A posted write is waiting in the buffer |
| job_addr | input | AW | Start byte address of that write |
| job_len | input | LW | Length of that write in DWORDs |
| job_ack | output | 1 | Job taken; the inputs may change next cycle |
| buf_rdata | input | DW | DWORD at the head of the buffer |
| buf_pop | output | 1 | Head DWORD was accepted by the target |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| lat_init | input | TW | Latency timer reload value |
| tx_frame | output | 1 | Transaction in progress (address or data cycle) |
| tx_addr_phase | output | 1 | Address cycle |
| tx_data_phase | output | 1 | Data cycle, initiator ready |
| tx_addr | output | AW | Address to drive in the address cycle |
| tx_wdata | output | DW | Write data for the current data cycle |
| tgt_ready | input | 1 | Target takes the data |
| tgt_disc | input | 1 | Target disconnect |
| tgt_retry | input | 1 | Target retry |
| tgt_abort | input | 1 | Target abort |
| xfer_done | output | 1 | Job completed in full |
| xfer_drop | output | 1 | Job ended by abort; remainder discarded |
| sts_abort | output | 1 | Sticky target-abort flag |
| sts_abort_clr | input | 1 | Write-one clear of `sts_abort` |

## Verification
The assertions check, on every cycle, the rules that hold locally:

- the request covers the frame;
- an address phase follows a grant;
- a pop only happens with an acceptable target response;
- the frame ends after retry, disconnect, completion or abort;
- the grant keeps a burst alive;
- the abort flag is set, held and cleared correctly.

Some behaviour only the bench scenarios can show, because it depends on history across several bursts:

- the restart address after several partial bursts;
- the exact cycle in which the latency timer ends a burst with the grant withdrawn;
- the count of DWORDs delivered against those discarded;
- the data order seen by the target.

// File: rtl/pws_pkg.sv
package pws_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_ADDR = 3'd2,
      ST_DATA = 3'd3,
      ST_TURN = 3'd4
   } seq_state_e;

   localparam int unsigned DWORD_BYTES = 4;

endpackage

// File: rtl/pws_lat_timer.sv
module pws_lat_timer #(
   parameter int TW       = 8,
   parameter int LT_STYLE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   input  logic [TW-1:0] init,
   output logic          expired
);

   generate
      if (LT_STYLE == 0) begin : g_down
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= init;
            end else if (run && cnt_q != '0) begin
               cnt_q <= cnt_q - TW'(1);
            end
         end
         assign expired = (cnt_q == '0);
      end else begin : g_up
         logic [TW-1:0] cnt_q;
         logic [TW-1:0] lim_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lim_q <= '0;
            end else if (load) begin
               cnt_q <= '0;
               lim_q <= init;
            end else if (run && cnt_q != lim_q) begin
               cnt_q <= cnt_q + TW'(1);
            end
         end
         assign expired = (cnt_q == lim_q);
      end
   endgenerate

endmodule

// File: rtl/pws_addr_gen.sv
module pws_addr_gen #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          step,
   output logic [AW-1:0] addr
);
   import pws_pkg::*;

   localparam logic [AW-1:0] STRIDE = AW'(DWORD_BYTES);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (start) begin
         addr_q <= start_addr;
      end else if (step) begin
         addr_q <= addr_q + STRIDE;
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl #(
   parameter int LW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          job_valid,
   input  logic [LW-1:0] job_len,
   input  logic          gnt,
   input  logic          tgt_ready,
   input  logic          tgt_disc,
   input  logic          tgt_retry,
   input  logic          tgt_abort,
   input  logic          lt_expired,
   output logic          job_ack,
   output logic          req,
   output logic          frame,
   output logic          addr_phase,
   output logic          data_phase,
   output logic          pop,
   output logic          done,
   output logic          drop,
   output logic          lt_load,
   output logic          lt_run
);
   import pws_pkg::*;

   seq_state_e    state_q, state_d;
   logic [LW-1:0] remain_q;
   logic          accept;
   logic          last;
   logic          early_end;

   assign accept    = tgt_ready && !tgt_retry && !tgt_abort;
   assign last      = (remain_q == LW'(1));
   assign early_end = tgt_retry || tgt_disc || (lt_expired && !gnt);

   always_comb begin
      state_d = state_q;
      job_ack = 1'b0;
      pop     = 1'b0;
      done    = 1'b0;
      drop    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (job_valid) begin
               job_ack = 1'b1;
               if (job_len == '0) begin
                  done = 1'b1;
               end else begin
                  state_d = ST_REQ;
               end
            end
         end
         ST_REQ: begin
            if (gnt) state_d = ST_ADDR;
         end
         ST_ADDR: begin
            state_d = ST_DATA;
         end
         ST_DATA: begin
            if (tgt_abort) begin
               drop    = 1'b1;
               state_d = ST_IDLE;
            end else begin
               pop = accept;
               if (accept && last) begin
                  done    = 1'b1;
                  state_d = ST_IDLE;
               end else if (early_end) begin
                  state_d = ST_TURN;
               end
            end
         end
         ST_TURN: begin
            state_d = ST_REQ;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
      end else begin
         state_q <= state_d;
         if (job_ack) begin
            remain_q <= job_len;
         end else if (pop) begin
            remain_q <= remain_q - LW'(1);
         end
      end
   end

   assign req        = (state_q != ST_IDLE);
   assign addr_phase = (state_q == ST_ADDR);
   assign data_phase = (state_q == ST_DATA);
   assign frame      = addr_phase || data_phase;
   assign lt_load    = addr_phase;
   assign lt_run     = data_phase;

endmodule

// File: rtl/pws_drain_seq.sv
module pws_drain_seq #(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int LW       = 10,
   parameter int TW       = 8,
   parameter int LT_STYLE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          job_valid,
   input  logic [AW-1:0] job_addr,
   input  logic [LW-1:0] job_len,
   output logic          job_ack,
   input  logic [DW-1:0] buf_rdata,
   output logic          buf_pop,
   output logic          bus_req,
   input  logic          bus_gnt,
   input  logic [TW-1:0] lat_init,
   output logic          tx_frame,
   output logic          tx_addr_phase,
   output logic          tx_data_phase,
   output logic [AW-1:0] tx_addr,
   output logic [DW-1:0] tx_wdata,
   input  logic          tgt_ready,
   input  logic          tgt_disc,
   input  logic          tgt_retry,
   input  logic          tgt_abort,
   output logic          xfer_done,
   output logic          xfer_drop,
   output logic          sts_abort,
   input  logic          sts_abort_clr
);

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("pws_drain_seq: AW must lie in 8..64");
      end
      if (DW < 8) begin : g_bad_dw
         $error("pws_drain_seq: DW must be at least 8");
      end
      if (LW < 1 || TW < 1) begin : g_bad_cnt
         $error("pws_drain_seq: LW and TW must be positive");
      end
      if (LT_STYLE != 0 && LT_STYLE != 1) begin : g_bad_style
         $error("pws_drain_seq: LT_STYLE must be 0 or 1");
      end
   endgenerate

   logic lt_load, lt_run, lt_expired;
   logic pop, drop;
   logic sts_q;

   pws_ctrl #(.LW(LW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .job_valid  (job_valid),
      .job_len    (job_len),
      .gnt        (bus_gnt),
      .tgt_ready  (tgt_ready),
      .tgt_disc   (tgt_disc),
      .tgt_retry  (tgt_retry),
      .tgt_abort  (tgt_abort),
      .lt_expired (lt_expired),
      .job_ack    (job_ack),
      .req        (bus_req),
      .frame      (tx_frame),
      .addr_phase (tx_addr_phase),
      .data_phase (tx_data_phase),
      .pop        (pop),
      .done       (xfer_done),
      .drop       (drop),
      .lt_load    (lt_load),
      .lt_run     (lt_run)
   );

   pws_lat_timer #(.TW(TW), .LT_STYLE(LT_STYLE)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (lt_load),
      .run     (lt_run),
      .init    (lat_init),
      .expired (lt_expired)
   );

   pws_addr_gen #(.AW(AW)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (job_ack),
      .start_addr (job_addr),
      .step       (pop),
      .addr       (tx_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= 1'b0;
      end else if (drop) begin
         sts_q <= 1'b1;
      end else if (sts_abort_clr) begin
         sts_q <= 1'b0;
      end
   end

   assign buf_pop   = pop;
   assign xfer_drop = drop;
   assign sts_abort = sts_q;
   assign tx_wdata  = buf_rdata;

endmodule

// File: rtl/pws_drain_seq_chk.sv
module pws_drain_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic bus_gnt,
   input logic tx_frame,
   input logic tx_addr_phase,
   input logic tx_data_phase,
   input logic tgt_ready,
   input logic tgt_disc,
   input logic tgt_retry,
   input logic tgt_abort,
   input logic buf_pop,
   input logic xfer_done,
   input logic xfer_drop,
   input logic sts_abort,
   input logic sts_abort_clr
);

   a_r1_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_addr_phase, tx_data_phase}));

   a_r10_req_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame |-> bus_req);

   a_r2_addr_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      tx_addr_phase |-> $past(bus_gnt));

   a_r3_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop |-> (tx_data_phase && tgt_ready && !tgt_retry && !tgt_abort));

   a_r4_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (!bus_req && !tx_frame));

   a_r5_stop_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_phase && (tgt_retry || tgt_disc)) |=> !tx_frame);

   a_r7_abort_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_phase && tgt_abort) |-> (!buf_pop && xfer_drop));

   a_r7_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_drop |=> (!bus_req && !tx_frame));

   a_r8_abort_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_phase && tgt_abort) |=> sts_abort);

   a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_abort && !sts_abort_clr) |=> sts_abort);

   a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_abort_clr && !(tx_data_phase && tgt_abort)) |=> !sts_abort);

   a_r9_grant_keeps_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_phase && bus_gnt && !tgt_retry && !tgt_disc && !tgt_abort && !xfer_done)
      |=> tx_data_phase);

   a_r10_turn_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tx_frame) && !$past(xfer_done) && !$past(xfer_drop)) |-> bus_req);

endmodule

bind pws_drain_seq pws_drain_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_req       (bus_req),
   .bus_gnt       (bus_gnt),
   .tx_frame      (tx_frame),
   .tx_addr_phase (tx_addr_phase),
   .tx_data_phase (tx_data_phase),
   .tgt_ready     (tgt_ready),
   .tgt_disc      (tgt_disc),
   .tgt_retry     (tgt_retry),
   .tgt_abort     (tgt_abort),
   .buf_pop       (buf_pop),
   .xfer_done     (xfer_done),
   .xfer_drop     (xfer_drop),
   .sts_abort     (sts_abort),
   .sts_abort_clr (sts_abort_clr)
);

// File: tb/tb_pws_drain_seq.sv
`timescale 1ns/1ps
module tb_pws_drain_seq;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 10;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          job_valid = 1'b0;
   logic [AW-1:0] job_addr = '0;
   logic [LW-1:0] job_len = '0;
   logic          job_ack;
   logic [DW-1:0] buf_rdata = '0;
   logic          buf_pop;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [TW-1:0] lat_init = '0;
   logic          tx_frame, tx_addr_phase, tx_data_phase;
   logic [AW-1:0] tx_addr;
   logic [DW-1:0] tx_wdata;
   logic          tgt_ready = 1'b0, tgt_disc = 1'b0, tgt_retry = 1'b0, tgt_abort = 1'b0;
   logic          xfer_done, xfer_drop, sts_abort;
   logic          sts_abort_clr = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int jid = 0;
   bit wd = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   pws_drain_seq #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) dut (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] dfun(input int j, input int idx);
      return {j[7:0] ^ 8'h5A, idx[7:0], 16'hC3A5};
   endfunction

   function automatic bit roll(input int pct);
      return ($urandom_range(99) < pct);
   endfunction

   task automatic run_job(input logic [31:0] a, input int len, input int lt,
                          input int p_rdy, input int p_disc, input int p_retry,
                          input int p_gdrop, input int abort_at, input bit clr_with_abort);
      int pops = 0, dcnt = 0, nph = 0;
      bit prev_gnt = 0, have_exp = 0, exp_frame = 0, exp_turn = 0, fin = 0, acked = 0;
      bit exp_pop, lastx, endx, aborted = 0;
      string tag = "R5";
      jid++;
      @(negedge clk);
      job_valid = 1'b1; job_addr = a; job_len = LW'(len); lat_init = TW'(lt);
      while (!fin) begin
         if (cyc > 150000) begin wd = 1'b1; break; end
         if (have_exp) chk(tx_frame == exp_frame, tag, tx_frame, exp_frame);
         if (exp_turn) chk(bus_req == 1'b1, "R10", bus_req, 1);
         if (acked) job_valid = 1'b0;
         buf_rdata = dfun(jid, pops);
         if (tx_frame) bus_gnt = !roll(p_gdrop);
         else bus_gnt = roll(70);
         if (tx_data_phase) begin
            tgt_abort = (abort_at >= 0 && pops == abort_at);
            tgt_ready = roll(p_rdy) || tgt_abort;
            tgt_disc  = roll(p_disc);
            tgt_retry = roll(p_retry);
            sts_abort_clr = tgt_abort && clr_with_abort;
         end else begin
            tgt_abort = 0; tgt_ready = 0; tgt_disc = 0; tgt_retry = 0; sts_abort_clr = 0;
         end
         #1;
         if (job_ack) acked = 1'b1;
         exp_pop = tx_data_phase && tgt_ready && !tgt_retry && !tgt_abort;
         chk(buf_pop == exp_pop, "R3", buf_pop, exp_pop);
         if (buf_pop) chk(tx_wdata == dfun(jid, pops), "R3", tx_wdata, dfun(jid, pops));
         if (tx_addr_phase) begin
            chk(prev_gnt, "R2", prev_gnt, 1);
            chk(tx_addr == a + 32'(4 * pops), (nph == 0) ? "R2" : "R6", tx_addr, a + 32'(4 * pops));
            nph++;
            dcnt = 0;
         end
         lastx = exp_pop && (pops + 1 == len);
         chk(xfer_done == lastx, "R4", xfer_done, lastx);
         chk(xfer_drop == (tx_data_phase && tgt_abort), "R7", xfer_drop, tx_data_phase && tgt_abort);
         exp_turn = 1'b0;
         if (tx_data_phase) begin
            endx = tgt_abort || tgt_retry || tgt_disc || lastx || (dcnt >= lt && !bus_gnt);
            if (tgt_abort) tag = "R7";
            else if (lastx) tag = "R4";
            else if (tgt_retry || tgt_disc) tag = "R5";
            else tag = "R9";
            have_exp = 1'b1;
            exp_frame = !endx;
            exp_turn = endx && !tgt_abort && !lastx;
            dcnt++;
         end else begin
            have_exp = 1'b0;
         end
         if (tgt_abort && tx_data_phase) aborted = 1'b1;
         prev_gnt = bus_gnt;
         if (buf_pop) pops++;
         fin = xfer_done || xfer_drop;
         @(negedge clk);
      end
      job_valid = 0; bus_gnt = 0; tgt_ready = 0; tgt_disc = 0; tgt_retry = 0; tgt_abort = 0;
      sts_abort_clr = 0;
      #1;
      chk(!bus_req && !tx_frame, aborted ? "R7" : "R4", {bus_req, tx_frame}, 0);
      if (aborted) begin
         chk(sts_abort == 1'b1, "R8", sts_abort, 1);
         chk(pops == abort_at, "R7", pops, abort_at);
      end else begin
         chk(pops == len, "R4", pops, len);
      end
   endtask

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!bus_req && !tx_frame && !tx_addr_phase && !tx_data_phase && !sts_abort, "R1",
          {bus_req, tx_frame, tx_addr_phase, tx_data_phase, sts_abort}, 0);

      // R11: empty job finishes at once
      @(negedge clk);
      job_valid = 1'b1; job_len = '0; job_addr = 32'h100;
      #1;
      chk(job_ack && xfer_done, "R11", {job_ack, xfer_done}, 2'b11);
      @(negedge clk);
      job_valid = 1'b0;
      #1;
      chk(!bus_req, "R11", bus_req, 0);

      // R4: clean burst, grant held
      run_job(32'h1000, 4, 10, 100, 0, 0, 0, -1, 0);
      // R5: frequent disconnect and retry, restart address R6
      run_job(32'h2000, 9, 10, 70, 20, 20, 0, -1, 0);
      // R9: grant withdrawn during every burst, timer governs
      run_job(32'h3000, 5, 3, 30, 0, 0, 100, -1, 0);
      run_job(32'h3100, 3, 0, 40, 0, 0, 100, -1, 0);
      // R9: grant held, short timer must not end the burst
      run_job(32'h3200, 4, 0, 25, 0, 0, 0, -1, 0);
      // R7, R8: abort with ready, clear in same cycle loses
      run_job(32'h4000, 6, 10, 100, 0, 0, 0, 2, 1);
      run_job(32'h5000, 2, 10, 100, 0, 0, 0, -1, 0);
      chk(sts_abort == 1'b1, "R8", sts_abort, 1);
      @(negedge clk); sts_abort_clr = 1'b1;
      @(negedge clk); sts_abort_clr = 1'b0;
      #1;
      chk(sts_abort == 1'b0, "R8", sts_abort, 0);

      // mixed random jobs
      for (int i = 0; i < 30 && !wd; i++) begin
         int len = $urandom_range(12, 1);
         int ab  = roll(15) ? $urandom_range(len - 1, 0) : -1;
         run_job({$urandom_range(32'hFFFF), 2'b00}, len, $urandom_range(7),
                 $urandom_range(90, 30), $urandom_range(15), $urandom_range(15),
                 $urandom_range(60), ab, 1'b0);
         if (sts_abort) begin
            @(negedge clk); sts_abort_clr = 1'b1;
            @(negedge clk); sts_abort_clr = 1'b0;
         end
      end

      if (wd) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule